// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice that computes `addend ± ((base ± offset) × coef + carry)` once per clock. A three-bit selector sets how the pre-adder combines its two 25-bit operands. It can add them, subtract the offset, pass either one alone, negate the offset or output zero. The 25-bit pre-adder result is multiplied by an 18-bit coefficient. The product is sign-extended to 48 bits, and a post-adder adds it to or subtracts it from a 48-bit addend together with a one-bit carry.

The slice fits symmetric filter taps, where two samples that share a coefficient are summed before the multiplication. It also fits plain multiply-accumulate work, with the pre-adder set to a single operand. Four register stages can each be switched on or off by a parameter: input, after the pre-adder, after the multiplier and after the post-adder. The selector and the add/subtract choice travel down the pipe with their own operands. A valid flag follows the data with the same latency.

Top module: `premac_slice`

## Requirements
- R1: With `pre_sel_i` bit 2 set, the pre-adder includes `base_i`. With bit 0 set, it includes `offs_i`, negated when bit 1 is also set. The eight codes therefore give 0, offset, 0, −offset, base, base+offset, base, base−offset for codes 0 to 7.
- R2: The pre-adder is 25 bits wide and has no saturation. Its sum wraps modulo 2^25 and is then read as a signed value.
- R3: The multiplier treats the 25-bit pre-adder result and `coef_i` as signed two's complement. Its 43-bit product is sign-extended to 48 bits.
- R4: With `post_sub_i` = 0, `res_o` = `addend_i` + product + `carry_i`. With `post_sub_i` = 1, `res_o` = `addend_i` − (product + `carry_i`). Both wrap modulo 2^48.
- R5: Latency in cycles equals `IN_STG + PRE_STG + MUL_STG + OUT_STG`, which is 4 by default. `out_valid_o` rises exactly that many cycles after `in_valid_i` and lasts one cycle for each cycle of input.
- R6: `pre_sel_i` and `post_sub_i` are captured in the same cycle as the operands. Changing them on every cycle applies each setting to its own operand set.
- R7: A synchronous active-high `rst_i` clears every pipeline register. `out_valid_o` and `res_o` read 0 after it, and operands already in flight are discarded.
- R8: Codes 0 and 2 give a zero product whatever the operands are, so `res_o` = `addend_i` ± `carry_i`.
- R9: A new operand set is accepted on every cycle, and back-to-back inputs produce results on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operand set valid |
| base_i | input | 25 | Signed pre-adder operand that can be bypassed |
| offs_i | input | 25 | Signed pre-adder operand that can be negated |
| coef_i | input | 18 | Signed multiplier operand |
| addend_i | input | 48 | Post-adder operand |
| carry_i | input | 1 | Carry into the post-adder |
| pre_sel_i | input | 3 | Pre-adder selector (see R1) |
| post_sub_i | input | 1 | 1 = subtract product from addend |
| out_valid_o | output | 1 | Result valid |
| res_o | output | 48 | Result |

## Verification
With the default parameters, a result is due exactly four rising edges after the operands are presented. The bench drives on falling edges. It compares the output for the operand set driven at falling edge k at falling edge k+4, so every register stage on the path has been counted. The latency scenario also checks that the valid flag is low one cycle early and again one cycle late. The burst scenario drives a new operand set on each cycle and samples each result four cycles after its own input. This catches any result that is early, late or out of step with its selector.

// File: rtl/premac_pkg.sv
`timescale 1ns/1ps
package premac_pkg;

    localparam int DEF_PRE_W  = 25;
    localparam int DEF_COEF_W = 18;
    localparam int DEF_ACC_W  = 48;
    localparam int SEL_W      = 3;

    // Selector fields: incl_base = bit 2, neg_offs = bit 1, incl_offs = bit 0
    typedef struct packed {
        logic incl_base;
        logic neg_offs;
        logic incl_offs;
    } pre_sel_t;

endpackage

// File: rtl/premac_preadd.sv
`timescale 1ns/1ps
module premac_preadd
    import premac_pkg::*;
#(
    parameter int W = DEF_PRE_W
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] offs_i,
    input  pre_sel_t     sel_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] base_term;
    logic [W-1:0] offs_term;

    always_comb begin
        base_term = sel_i.incl_base ? base_i : '0;
        if (!sel_i.incl_offs) begin
            offs_term = '0;
        end else if (sel_i.neg_offs) begin
            offs_term = '0 - offs_i;
        end else begin
            offs_term = offs_i;
        end
        // No saturation: wraps modulo 2^W
        sum_o = base_term + offs_term;
    end

endmodule

// File: rtl/premac_mult.sv
`timescale 1ns/1ps
module premac_mult #(
    parameter int XW = 25,
    parameter int YW = 18,
    parameter int OW = 48
) (
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    output logic [OW-1:0] p_o
);

    localparam int PW  = XW + YW;
    localparam int EXT = OW - PW;

    logic [PW-1:0] x_ext;
    logic [PW-1:0] y_ext;
    logic [PW-1:0] prod;

    always_comb begin
        x_ext = {{YW{x_i[XW-1]}}, x_i};
        y_ext = {{XW{y_i[YW-1]}}, y_i};
        // Low PW bits of the extended product equal the signed product
        prod  = x_ext * y_ext;
        p_o   = {{EXT{prod[PW-1]}}, prod};
    end

endmodule

// File: rtl/premac_postadd.sv
`timescale 1ns/1ps
module premac_postadd #(
    parameter int W = 48
) (
    input  logic [W-1:0] addend_i,
    input  logic [W-1:0] prod_i,
    input  logic         carry_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] term;

    always_comb begin
        term  = prod_i + {{(W-1){1'b0}}, carry_i};
        sum_o = sub_i ? (addend_i - term) : (addend_i + term);
    end

endmodule

// File: rtl/premac_slice.sv
`timescale 1ns/1ps
module premac_slice
    import premac_pkg::*;
#(
    parameter int PRE_W   = DEF_PRE_W,
    parameter int COEF_W  = DEF_COEF_W,
    parameter int ACC_W   = DEF_ACC_W,
    parameter bit IN_STG  = 1'b1,
    parameter bit PRE_STG = 1'b1,
    parameter bit MUL_STG = 1'b1,
    parameter bit OUT_STG = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic [PRE_W-1:0]  base_i,
    input  logic [PRE_W-1:0]  offs_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic [ACC_W-1:0]  addend_i,
    input  logic              carry_i,
    input  logic [SEL_W-1:0]  pre_sel_i,
    input  logic              post_sub_i,
    output logic              out_valid_o,
    output logic [ACC_W-1:0]  res_o
);

    localparam int LATENCY = int'(IN_STG) + int'(PRE_STG) + int'(MUL_STG) + int'(OUT_STG);

    typedef struct packed {
        logic              vld;
        logic [PRE_W-1:0]  base;
        logic [PRE_W-1:0]  offs;
        logic [COEF_W-1:0] coef;
        logic [ACC_W-1:0]  addend;
        logic              carry;
        pre_sel_t          sel;
        logic              sub;
    } in_stage_t;

    typedef struct packed {
        logic              vld;
        logic [PRE_W-1:0]  pre;
        logic [COEF_W-1:0] coef;
        logic [ACC_W-1:0]  addend;
        logic              carry;
        logic              sub;
    } pre_stage_t;

    typedef struct packed {
        logic              vld;
        logic [ACC_W-1:0]  prod;
        logic [ACC_W-1:0]  addend;
        logic              carry;
        logic              sub;
    } mul_stage_t;

    typedef struct packed {
        logic              vld;
        logic [ACC_W-1:0]  res;
    } out_stage_t;

    in_stage_t  in_d,  in_q;
    pre_stage_t pre_d, pre_q;
    mul_stage_t mul_d, mul_q;
    out_stage_t out_d, out_q;

    logic [PRE_W-1:0] pre_sum;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] post_sum;

    // Stage 0: capture operands and controls together
    always_comb begin
        in_d.vld    = in_valid_i;
        in_d.base   = base_i;
        in_d.offs   = offs_i;
        in_d.coef   = coef_i;
        in_d.addend = addend_i;
        in_d.carry  = carry_i;
        in_d.sel    = pre_sel_t'(pre_sel_i);
        in_d.sub    = post_sub_i;
    end

    premac_preadd #(.W(PRE_W)) u_preadd (
        .base_i (in_q.base),
        .offs_i (in_q.offs),
        .sel_i  (in_q.sel),
        .sum_o  (pre_sum)
    );

    always_comb begin
        pre_d.vld    = in_q.vld;
        pre_d.pre    = pre_sum;
        pre_d.coef   = in_q.coef;
        pre_d.addend = in_q.addend;
        pre_d.carry  = in_q.carry;
        pre_d.sub    = in_q.sub;
    end

    premac_mult #(.XW(PRE_W), .YW(COEF_W), .OW(ACC_W)) u_mult (
        .x_i (pre_q.pre),
        .y_i (pre_q.coef),
        .p_o (prod_ext)
    );

    always_comb begin
        mul_d.vld    = pre_q.vld;
        mul_d.prod   = prod_ext;
        mul_d.addend = pre_q.addend;
        mul_d.carry  = pre_q.carry;
        mul_d.sub    = pre_q.sub;
    end

    premac_postadd #(.W(ACC_W)) u_post (
        .addend_i (mul_q.addend),
        .prod_i   (mul_q.prod),
        .carry_i  (mul_q.carry),
        .sub_i    (mul_q.sub),
        .sum_o    (post_sum)
    );

    always_comb begin
        out_d.vld = mul_q.vld;
        out_d.res = post_sum;
    end

    // Each stage either registers its next value or passes it straight on
    generate
        if (IN_STG) begin : g_in_reg
            always_ff @(posedge clk_i) begin
                if (rst_i) in_q <= '0;
                else       in_q <= in_d;
            end
        end else begin : g_in_thru
            always_comb in_q = in_d;
        end

        if (PRE_STG) begin : g_pre_reg
            always_ff @(posedge clk_i) begin
                if (rst_i) pre_q <= '0;
                else       pre_q <= pre_d;
            end
        end else begin : g_pre_thru
            always_comb pre_q = pre_d;
        end

        if (MUL_STG) begin : g_mul_reg
            always_ff @(posedge clk_i) begin
                if (rst_i) mul_q <= '0;
                else       mul_q <= mul_d;
            end
        end else begin : g_mul_thru
            always_comb mul_q = mul_d;
        end

        if (OUT_STG) begin : g_out_reg
            always_ff @(posedge clk_i) begin
                if (rst_i) out_q <= '0;
                else       out_q <= out_d;
            end
        end else begin : g_out_thru
            always_comb out_q = out_d;
        end
    endgenerate

    assign out_valid_o = out_q.vld;
    assign res_o       = out_q.res;

    // Taps for the bound checker
    logic [SEL_W-1:0] chk_sel;
    logic [PRE_W-1:0] chk_base;
    assign chk_sel  = in_q.sel;
    assign chk_base = in_q.base;

endmodule

// File: rtl/premac_slice_chk.sv
`timescale 1ns/1ps
module premac_slice_chk #(
    parameter int PRE_W  = 25,
    parameter int COEF_W = 18,
    parameter int ACC_W  = 48,
    parameter int LAT    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PRE_W-1:0]  base,
    input logic [PRE_W-1:0]  offs,
    input logic [COEF_W-1:0] coef,
    input logic [ACC_W-1:0]  addend,
    input logic              carry,
    input logic [2:0]        sel,
    input logic              sub,
    input logic              out_valid,
    input logic [ACC_W-1:0]  res,
    input logic [2:0]        stg_sel,
    input logic [PRE_W-1:0]  stg_base,
    input logic [PRE_W-1:0]  pre_sum
);

    localparam int PW = PRE_W + COEF_W;

    logic             shv [0:LAT];
    logic [ACC_W-1:0] shr [0:LAT];

    logic signed [PRE_W-1:0] m_pre;
    logic signed [PW-1:0]    m_prod;
    logic [ACC_W-1:0]        m_term;

    always_comb begin
        m_pre  = (sel[2] ? $signed(base) : '0)
               + (sel[0] ? (sel[1] ? -$signed(offs) : $signed(offs)) : '0);
        m_prod = PW'(m_pre) * PW'($signed(coef));
        m_term = ACC_W'(m_prod) + ACC_W'(carry);
        shv[0] = in_valid;
        shr[0] = sub ? addend - m_term : addend + m_term;
    end

    for (genvar i = 1; i <= LAT; i++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                shv[i] <= 1'b0;
                shr[i] <= '0;
            end else begin
                shv[i] <= shv[i-1];
                shr[i] <= shr[i-1];
            end
        end
    end

    p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid == shv[LAT]);

    p_result_value_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> res == shr[LAT]);

    p_zero_select_r8: assert property (@(posedge clk) disable iff (rst)
        (!stg_sel[0] && !stg_sel[2]) |-> pre_sum == '0);

    p_base_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (stg_sel[2] && !stg_sel[0]) |-> pre_sum == stg_base);

    generate
        if (LAT > 0) begin : g_rst_chk
            p_reset_clears_r7: assert property (@(posedge clk)
                rst |=> (!out_valid && res == '0));
        end
    endgenerate

endmodule

bind premac_slice premac_slice_chk #(
    .PRE_W  (PRE_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W),
    .LAT    (LATENCY)
) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .in_valid  (in_valid_i),
    .base      (base_i),
    .offs      (offs_i),
    .coef      (coef_i),
    .addend    (addend_i),
    .carry     (carry_i),
    .sel       (pre_sel_i),
    .sub       (post_sub_i),
    .out_valid (out_valid_o),
    .res       (res_o),
    .stg_sel   (chk_sel),
    .stg_base  (chk_base),
    .pre_sum   (pre_sum)
);

// File: tb/tb_premac_slice.sv
`timescale 1ns/1ps
module tb_premac_slice;

    localparam int LAT = 4;
    localparam int MAXN = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [24:0] base, offs;
    logic [17:0] coef;
    logic [47:0] addend;
    logic        carry;
    logic [2:0]  sel;
    logic        sub;
    logic        out_valid;
    logic [47:0] res;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [24:0] va [MAXN];
    logic [24:0] vd [MAXN];
    logic [17:0] vb [MAXN];
    logic [47:0] vc [MAXN];
    logic        vci[MAXN];
    logic [2:0]  vm [MAXN];
    logic        vs [MAXN];
    logic [47:0] ve [MAXN];
    int n;

    always #2.5 clk = ~clk;

    premac_slice dut (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid),
        .base_i(base), .offs_i(offs), .coef_i(coef), .addend_i(addend),
        .carry_i(carry), .pre_sel_i(sel), .post_sub_i(sub),
        .out_valid_o(out_valid), .res_o(res)
    );

    function automatic logic [47:0] model(logic [24:0] d, logic [24:0] a, logic [17:0] b,
                                          logic [47:0] c, logic ci, logic [2:0] m, logic s);
        logic [24:0] pre;
        logic signed [42:0] p;
        logic [47:0] t;
        pre = (m[2] ? d : 25'd0) + (m[0] ? (m[1] ? 25'd0 - a : a) : 25'd0);
        p = 43'($signed(pre)) * 43'($signed(b));
        t = {{5{p[42]}}, p} + {47'd0, ci};
        return s ? c - t : c + t;
    endfunction

    task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = 0; base = 0; offs = 0; coef = 0; addend = 0;
        carry = 0; sel = 0; sub = 0;
    endtask

    task automatic add(logic [24:0] d, logic [24:0] a, logic [17:0] b, logic [47:0] c,
                       logic ci, logic [2:0] m, logic s, logic [47:0] e);
        vd[n] = d; va[n] = a; vb[n] = b; vc[n] = c; vci[n] = ci;
        vm[n] = m; vs[n] = s; ve[n] = e;
        n++;
    endtask

    task automatic addm(logic [24:0] d, logic [24:0] a, logic [17:0] b, logic [47:0] c,
                        logic ci, logic [2:0] m, logic s);
        add(d, a, b, c, ci, m, s, model(d, a, b, c, ci, m, s));
    endtask

    // Drive entries on consecutive falling edges; result i is due LAT falling edges later
    task automatic run_batch(string req);
        for (int i = 0; i < n + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                chk({req, " valid"}, {47'd0, out_valid}, 48'd1);
                chk(req, res, ve[i-LAT]);
            end
            if (i < n) begin
                in_valid = 1; base = vd[i]; offs = va[i]; coef = vb[i];
                addend = vc[i]; carry = vci[i]; sel = vm[i]; sub = vs[i];
            end else begin
                idle();
            end
        end
        @(negedge clk);
        chk({req, " tail"}, {47'd0, out_valid}, 48'd0);
        n = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R7 reset valid", {47'd0, out_valid}, 48'd0);
        chk("R7 reset result", res, 48'd0);
        // Put data in flight, then reset
        in_valid = 1; base = 25'd9; offs = 25'd4; coef = 18'd7; addend = 48'd3; sel = 3'b101;
        @(negedge clk);
        idle();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < LAT + 1; i++) begin
            chk("R7 flushed valid", {47'd0, out_valid}, 48'd0);
            chk("R7 flushed result", res, 48'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_modes();
        for (int m = 0; m < 8; m++)
            addm(25'd100, 25'd5, 18'd3, 48'd1000, 1'b0, 3'(m), 1'b0);
        run_batch("R1 modes");
    endtask

    task automatic t_wrap();
        // 0x0FFFFFF + 1 wraps to -2^24, times 2 = -2^25
        add(25'h0FFFFFF, 25'd1, 18'd2, 48'd0, 1'b0, 3'b101, 1'b0, 48'hFFFF_FE00_0000);
        // -2^24 - 1 wraps to 2^24-1
        add(25'h1000000, 25'd1, 18'd1, 48'd0, 1'b0, 3'b111, 1'b0, 48'h0000_00FF_FFFF);
        run_batch("R2 wrap");
    endtask

    task automatic t_mult();
        // -2^24 * -2^17 = 2^41
        add(25'd0, 25'h1000000, 18'h20000, 48'd0, 1'b0, 3'b001, 1'b0, 48'h0200_0000_0000);
        // -7 * 9 = -63, sign-extended
        add(25'd0, 25'h1FFFFF9, 18'd9, 48'd0, 1'b0, 3'b001, 1'b0, 48'hFFFF_FFFF_FFC1);
        // -A mode: -(5) * -3 = 15
        add(25'd0, 25'd5, 18'h3FFFD, 48'd0, 1'b0, 3'b011, 1'b0, 48'd15);
        run_batch("R3 signed mult");
    endtask

    task automatic t_post();
        add(25'd0, 25'd10, 18'd10, 48'd0, 1'b1, 3'b001, 1'b1, 48'hFFFF_FFFF_FF9B);
        add(25'd0, 25'd0, 18'd0, 48'h7FFF_FFFF_FFFF, 1'b1, 3'b000, 1'b0, 48'h8000_0000_0000);
        add(25'd0, 25'd0, 18'd0, 48'd0, 1'b1, 3'b000, 1'b1, 48'hFFFF_FFFF_FFFF);
        add(25'd2, 25'd0, 18'd4, 48'd20, 1'b0, 3'b100, 1'b1, 48'd12);
        run_batch("R4 post add");
    endtask

    task automatic t_zero();
        add(25'h0ABCDEF, 25'h1234567, 18'h1FFFF, 48'd50, 1'b1, 3'b000, 1'b0, 48'd51);
        add(25'h0ABCDEF, 25'h1234567, 18'h1FFFF, 48'd50, 1'b1, 3'b010, 1'b1, 48'd49);
        run_batch("R8 zero select");
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1; base = 25'd6; offs = 25'd0; coef = 18'd7; addend = 48'd0; sel = 3'b100;
        @(negedge clk);
        idle();
        for (int k = 1; k <= LAT + 1; k++) begin
            if (k == LAT) begin
                chk("R5 valid on time", {47'd0, out_valid}, 48'd1);
                chk("R5 result on time", res, 48'd42);
            end else begin
                chk("R5 valid off time", {47'd0, out_valid}, 48'd0);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_burst();
        for (int i = 0; i < 10; i++)
            addm(25'(i * 37 + 3), 25'(i * 11 - 40), 18'(i * 5 - 17), 48'(i * 1000),
                 1'(i), 3'(i % 8), 1'(i / 2));
        run_batch("R6 R9 burst");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        n = 0;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_modes();
        t_wrap();
        t_mult();
        t_post();
        t_zero();
        t_latency();
        t_burst();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule